// File: doc/BRIEF.md
# Full-Search SAD Motion Estimator with Early Exit

This block finds the integer motion vector of one square block of pixels. It scans every candidate position inside a square search window of a reference area and scores each candidate with the sum of absolute differences (SAD) between the current block and the candidate. It reports the offset and the SAD of the lowest-scoring candidate. Two local scratchpads supply the pixels. One holds the current block and one holds the reference area, and each is loaded through its own write port before a search starts.

Each candidate takes one pixel pair per clock. At the end of every row of the block, the running sum is compared with the best SAD found so far. If the running sum has already reached that value, the candidate is dropped and the scan moves on to the next one. This can save most of the block's cycles on poor candidates. The first candidate is always summed in full, because it seeds the best value.

A search begins on a `start` pulse while the block is idle. It ends with a one-cycle `done` pulse. The results stay on the outputs until the next search starts.

Top module: `sad_block_matcher`

## Requirements
- R1: When `done` is high, `best_sad` equals the exact sum of |cur(x,y) − ref(x+cx, y+cy)| over the whole block for the reported candidate. Pixels are PIX_W-bit unsigned values.
- R2: The reported candidate has the smallest full SAD of all candidates. When SADs are equal, the candidate visited first is kept.
- R3: The scratchpad layout and scan order are as follows.
  - The current pixel (x,y) is stored at address y·BLK+x.
  - The reference area is W = BLK+SRCH−1 pixels on a side, and its pixel (x,y) is stored at address y·W+x.
  - Candidate indices cx and cy each run from 0 to SRCH−1. cy is the outer loop and cx the inner loop, both counting up.
  - The reported vector is two's complement: `best_mvx` = cx − SRCH/2 and `best_mvy` = cy − SRCH/2.
- R4: The early-exit test runs after each complete row of a candidate, except the last row. If the candidate is not the first one and its running sum is greater than or equal to the best SAD so far, the candidate is dropped.
  - A dropped candidate costs r·BLK+1 cycles, where r is the number of completed rows.
  - A candidate that runs to completion costs BLK·BLK cycles.
- R5: The first candidate is always summed over the full block. Its SAD becomes the initial best, even when it is zero.
- R6: `done` is high for exactly one cycle. Take S as the sum of the per-candidate costs, reduced by one if the last candidate was dropped. `done` is first high in the cycle that follows clock edge number S+1 after the edge that accepts `start`.
- R7: `start` is accepted only while `busy` is low. `busy` goes high at the edge that accepts `start`, and it is low again from the edge that raises `done`. A `start` pulse during a search has no effect on its results or its timing.
- R8: After a synchronous active-low reset, `busy` and `done` are low and `best_sad`, `best_mvx` and `best_mvy` are zero.
- R9: The results hold their values after `done` until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cur_we | input | 1 | Write strobe for the current-block scratchpad |
| cur_waddr | input | CUR_AW | Current-block write address (y·BLK+x) |
| cur_wdata | input | PIX_W | Current-block pixel |
| ref_we | input | 1 | Write strobe for the reference-area scratchpad |
| ref_waddr | input | REF_AW | Reference write address (y·W+x) |
| ref_wdata | input | PIX_W | Reference pixel |
| start | input | 1 | Begin a search (accepted when idle) |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| best_mvx | output | MV_W | Horizontal offset of best candidate, signed |
| best_mvy | output | MV_W | Vertical offset of best candidate, signed |
| best_sad | output | SAD_W | SAD of best candidate |

## Verification
The search is exercised on a small 4×4 block with a 4×4 window. The testbench plants an exact copy of the current block at each of the sixteen candidate positions in turn, which checks the vector sign convention and the address arithmetic at every offset. Uniform images with zero difference make every candidate after the first drop out after one row. Uniform images with maximum contrast make every candidate tie at the largest possible sum without any early exit. Between them these two separate the tie rule from the exit rule, and the measured cycle count to `done` shows whether early exit happened at all. Pseudo-random and gradient images with no planted match, plus a stray `start` in the middle of a search, check the general minimum and the rule that ignores `start` while busy.

// File: rtl/sad_pkg.sv
// Shared definitions for the SAD motion estimator.
// Assumes unsigned pixels of PIX_W bits.
package sad_pkg;

    localparam int PIX_W = 8;

    // Position markers that travel with each pixel pair through the read stage
    typedef struct packed {
        logic first;      // first pixel of a candidate
        logic row_end;    // last pixel of a block row
        logic blk_end;    // last pixel of the block
        logic last_cand;  // pixel belongs to the final candidate
    } scan_flag_t;

    // Absolute difference of two unsigned pixels
    function automatic logic [PIX_W-1:0] abs_diff(input logic [PIX_W-1:0] a,
                                                  input logic [PIX_W-1:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

endpackage

// File: rtl/sad_spad.sv
// Scratchpad: single write port, synchronous read port, one-cycle read latency.
// Assumes the read address is always inside DEPTH; contents are not reset.
module sad_spad #(
    parameter int DEPTH = 256,
    parameter int AW    = 8,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] mem [DEPTH];

    // Write port and registered read
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end

endmodule

// File: rtl/sad_scan_ctrl.sv
// Candidate sequencer. Walks candidates in raster order (cy outer, cx inner),
// and for each one walks the block pixels in raster order, one per clock.
// On abort it drops the rest of the current candidate and continues with
// the next one. Assumes abort arrives only while active.
module sad_scan_ctrl
    import sad_pkg::*;
#(
    parameter int BLK    = 16,
    parameter int SRCH   = 32,
    parameter int CUR_AW = 8,
    parameter int REF_AW = 12,
    parameter int CI_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_acc,
    input  logic              abort,
    output logic              active,
    output logic [CUR_AW-1:0] cur_raddr,
    output logic [REF_AW-1:0] ref_raddr,
    output scan_flag_t        flags,
    output logic [CI_W-1:0]   cdx,
    output logic [CI_W-1:0]   cdy
);

    localparam int PW    = (BLK > 1) ? $clog2(BLK) : 1;
    localparam int REF_W = BLK + SRCH - 1;
    localparam int REF_D = REF_W * REF_W;

    logic [PW-1:0] px, py;
    logic          px_last, py_last, cand_last;

    assign px_last   = (px == PW'(BLK - 1));
    assign py_last   = (py == PW'(BLK - 1));
    assign cand_last = (cdx == CI_W'(SRCH - 1)) && (cdy == CI_W'(SRCH - 1));

    // Address generation for both scratchpads
    assign cur_raddr = CUR_AW'(int'(py) * BLK + int'(px));
    assign ref_raddr = REF_AW'((int'(py) + int'(cdy)) * REF_W + int'(px) + int'(cdx));

    // Position markers for the pixel being issued
    always_comb begin
        flags.first     = (px == '0) && (py == '0);
        flags.row_end   = px_last;
        flags.blk_end   = px_last && py_last;
        flags.last_cand = cand_last;
    end

    // Pixel and candidate counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            px     <= '0;
            py     <= '0;
            cdx    <= '0;
            cdy    <= '0;
        end else if (!active) begin
            if (start_acc) begin
                active <= 1'b1;
                px     <= '0;
                py     <= '0;
                cdx    <= '0;
                cdy    <= '0;
            end
        end else if (abort || (px_last && py_last)) begin
            px <= '0;
            py <= '0;
            if (cand_last) begin
                active <= 1'b0;
            end else if (cdx == CI_W'(SRCH - 1)) begin
                cdx <= '0;
                cdy <= cdy + 1'b1;
            end else begin
                cdx <= cdx + 1'b1;
            end
        end else if (px_last) begin
            px <= '0;
            py <= py + 1'b1;
        end else begin
            px <= px + 1'b1;
        end
    end

    // R3: every issued reference address stays inside the reference area
    p_ref_addr_in_area_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (int'(ref_raddr) < REF_D));

endmodule

// File: rtl/sad_accum_cmp.sv
// Absolute-difference accumulator, early-exit comparator and best tracker.
// Takes the markers issued one cycle earlier, aligned with the scratchpad
// read data. Raises abort at a row end when the partial sum cannot win.
// Assumes start_acc arrives only while idle.
module sad_accum_cmp
    import sad_pkg::*;
#(
    parameter int SRCH  = 32,
    parameter int CI_W  = 5,
    parameter int MV_W  = 6,
    parameter int SAD_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_acc,
    input  logic                    issue_valid,
    input  scan_flag_t              issue_flags,
    input  logic [CI_W-1:0]         issue_cdx,
    input  logic [CI_W-1:0]         issue_cdy,
    input  logic [PIX_W-1:0]        cur_pix,
    input  logic [PIX_W-1:0]        ref_pix,
    output logic                    abort,
    output logic                    pipe_busy,
    output logic                    done,
    output logic signed [MV_W-1:0]  best_mvx,
    output logic signed [MV_W-1:0]  best_mvy,
    output logic [SAD_W-1:0]        best_sad
);

    localparam int HALF = SRCH / 2;

    logic             v_q;
    scan_flag_t       fl_q;
    logic [CI_W-1:0]  cdx_q, cdy_q;
    logic [SAD_W-1:0] acc_q, acc_next;
    logic             have_best;
    logic             take_best;
    logic             finish;
    logic signed [MV_W-1:0] mvx_now, mvy_now;

    // Running sum including the pixel pair that arrives this cycle
    assign acc_next = (fl_q.first ? '0 : acc_q) + SAD_W'(abs_diff(cur_pix, ref_pix));

    // Early exit: a row has finished, more rows remain, and the candidate cannot win
    assign abort = v_q && fl_q.row_end && !fl_q.blk_end && have_best && (acc_next >= best_sad);

    // A full candidate replaces the best only when it is strictly lower
    assign take_best = v_q && fl_q.blk_end && (!have_best || (acc_next < best_sad));

    // The search ends when the final candidate completes or is dropped
    assign finish = v_q && fl_q.last_cand && (fl_q.blk_end || abort);

    assign mvx_now   = $signed({1'b0, cdx_q}) - $signed(MV_W'(HALF));
    assign mvy_now   = $signed({1'b0, cdy_q}) - $signed(MV_W'(HALF));
    assign pipe_busy = v_q;

    // Read-stage alignment of markers; the issue made in an abort cycle is discarded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_q   <= 1'b0;
            fl_q  <= '0;
            cdx_q <= '0;
            cdy_q <= '0;
        end else begin
            v_q   <= issue_valid && !abort;
            fl_q  <= issue_flags;
            cdx_q <= issue_cdx;
            cdy_q <= issue_cdy;
        end
    end

    // Accumulator register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (v_q) begin
            acc_q <= acc_next;
        end
    end

    // Best-result tracking and end-of-search pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            have_best <= 1'b0;
            best_sad  <= '0;
            best_mvx  <= '0;
            best_mvy  <= '0;
            done      <= 1'b0;
        end else begin
            done <= finish;
            if (start_acc) begin
                have_best <= 1'b0;
            end else if (take_best) begin
                have_best <= 1'b1;
                best_sad  <= acc_next;
                best_mvx  <= mvx_now;
                best_mvy  <= mvy_now;
            end
        end
    end

    // R2: once a best exists within a search, it never gets worse
    p_best_never_rises_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (have_best && $past(have_best)) |-> (best_sad <= $past(best_sad)));

    // R5: the first candidate of a search never gets dropped
    p_no_drop_before_best_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (v_q && !have_best) |-> !abort);

endmodule

// File: rtl/sad_block_matcher.sv
// Full-search integer motion estimator with row-granular early exit.
// Current block BLK x BLK, search window SRCH x SRCH candidates, reference
// area (BLK+SRCH-1) squared. Scratchpads are loaded through the write
// ports while idle. Results are valid on done and held until the next start.
module sad_block_matcher
    import sad_pkg::*;
#(
    parameter  int BLK    = 16,
    parameter  int SRCH   = 32,
    localparam int REF_W  = BLK + SRCH - 1,
    localparam int CUR_D  = BLK * BLK,
    localparam int REF_D  = REF_W * REF_W,
    localparam int CUR_AW = $clog2(CUR_D),
    localparam int REF_AW = $clog2(REF_D),
    localparam int CI_W   = $clog2(SRCH),
    localparam int MV_W   = CI_W + 1,
    localparam int SAD_W  = $clog2(CUR_D * ((1 << PIX_W) - 1) + 1)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cur_we,
    input  logic [CUR_AW-1:0]      cur_waddr,
    input  logic [PIX_W-1:0]       cur_wdata,
    input  logic                   ref_we,
    input  logic [REF_AW-1:0]      ref_waddr,
    input  logic [PIX_W-1:0]       ref_wdata,
    input  logic                   start,
    output logic                   busy,
    output logic                   done,
    output logic signed [MV_W-1:0] best_mvx,
    output logic signed [MV_W-1:0] best_mvy,
    output logic [SAD_W-1:0]       best_sad
);

    logic              scan_active, pipe_busy, abort, start_acc;
    logic [CUR_AW-1:0] cur_raddr;
    logic [REF_AW-1:0] ref_raddr;
    logic [PIX_W-1:0]  cur_pix, ref_pix;
    scan_flag_t        flags;
    logic [CI_W-1:0]   cdx, cdy;

    assign busy      = scan_active || pipe_busy;
    assign start_acc = start && !busy;

    sad_spad #(.DEPTH(CUR_D), .AW(CUR_AW), .DW(PIX_W)) u_cur_spad (
        .clk(clk), .we(cur_we), .waddr(cur_waddr), .wdata(cur_wdata),
        .raddr(cur_raddr), .rdata(cur_pix)
    );

    sad_spad #(.DEPTH(REF_D), .AW(REF_AW), .DW(PIX_W)) u_ref_spad (
        .clk(clk), .we(ref_we), .waddr(ref_waddr), .wdata(ref_wdata),
        .raddr(ref_raddr), .rdata(ref_pix)
    );

    sad_scan_ctrl #(
        .BLK(BLK), .SRCH(SRCH), .CUR_AW(CUR_AW), .REF_AW(REF_AW), .CI_W(CI_W)
    ) u_scan (
        .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .abort(abort),
        .active(scan_active), .cur_raddr(cur_raddr), .ref_raddr(ref_raddr),
        .flags(flags), .cdx(cdx), .cdy(cdy)
    );

    sad_accum_cmp #(
        .SRCH(SRCH), .CI_W(CI_W), .MV_W(MV_W), .SAD_W(SAD_W)
    ) u_acc (
        .clk(clk), .rst_n(rst_n), .start_acc(start_acc),
        .issue_valid(scan_active), .issue_flags(flags),
        .issue_cdx(cdx), .issue_cdy(cdy),
        .cur_pix(cur_pix), .ref_pix(ref_pix),
        .abort(abort), .pipe_busy(pipe_busy), .done(done),
        .best_mvx(best_mvx), .best_mvy(best_mvy), .best_sad(best_sad)
    );

    // R4: a drop decision only ever comes while the sequencer is mid-scan
    p_drop_while_scanning_r4: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> scan_active);

    // R6: done is a single-cycle pulse
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7: the block is idle whenever done is raised
    p_idle_at_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

endmodule

// File: tb/tb_sad_block_matcher.sv
module tb_sad_block_matcher;

    localparam int B      = 4;
    localparam int S      = 4;
    localparam int H      = S / 2;
    localparam int RW     = B + S - 1;
    localparam int CUR_AW = 4;
    localparam int REF_AW = 6;
    localparam int MV_W   = 3;
    localparam int SAD_W  = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cur_we = 1'b0, ref_we = 1'b0, start = 1'b0;
    logic [CUR_AW-1:0] cur_waddr = '0;
    logic [REF_AW-1:0] ref_waddr = '0;
    logic [7:0] cur_wdata = '0, ref_wdata = '0;
    logic busy, done;
    logic signed [MV_W-1:0] best_mvx, best_mvy;
    logic [SAD_W-1:0] best_sad;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;
    int curm [B*B];
    int refm [RW*RW];
    int unsigned seed = 32'h1234_5678;

    always #10 clk = ~clk;

    sad_block_matcher #(.BLK(B), .SRCH(S)) dut (
        .clk(clk), .rst_n(rst_n), .cur_we(cur_we), .cur_waddr(cur_waddr),
        .cur_wdata(cur_wdata), .ref_we(ref_we), .ref_waddr(ref_waddr),
        .ref_wdata(ref_wdata), .start(start), .busy(busy), .done(done),
        .best_mvx(best_mvx), .best_mvy(best_mvy), .best_sad(best_sad)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int rnd();
        seed = seed * 1103515245 + 12345;
        return int'((seed >> 16) & 255);
    endfunction

    // Independent reference model: SAD, winner, and cycle count per R1-style rules
    task automatic model(output int esad, output int edx, output int edy, output int ecyc);
        int best = 0;
        bit hb = 1'b0;
        int cost = 0;
        bit last_drop = 1'b0;
        edx = 0;
        edy = 0;
        for (int cy = 0; cy < S; cy++) begin
            for (int cx = 0; cx < S; cx++) begin
                int acc = 0;
                bit dropped = 1'b0;
                int rows = 0;
                for (int y = 0; y < B; y++) begin
                    for (int x = 0; x < B; x++) begin
                        int d = curm[y*B+x] - refm[(y+cy)*RW + x + cx];
                        acc += (d < 0) ? -d : d;
                    end
                    if (y != B-1 && hb && acc >= best) begin
                        dropped = 1'b1;
                        rows = y + 1;
                        break;
                    end
                end
                if (dropped) begin
                    cost += rows * B + 1;
                end else begin
                    cost += B * B;
                    if (!hb || acc < best) begin
                        best = acc;
                        hb = 1'b1;
                        edx = cx - H;
                        edy = cy - H;
                    end
                end
                last_drop = dropped;
            end
        end
        esad = best;
        ecyc = (last_drop ? cost - 1 : cost) + 1;
    endtask

    task automatic load();
        for (int i = 0; i < B*B; i++) begin
            @(negedge clk);
            cur_we = 1'b1; cur_waddr = CUR_AW'(i); cur_wdata = 8'(curm[i]);
        end
        @(negedge clk); cur_we = 1'b0;
        for (int i = 0; i < RW*RW; i++) begin
            @(negedge clk);
            ref_we = 1'b1; ref_waddr = REF_AW'(i); ref_wdata = 8'(refm[i]);
        end
        @(negedge clk); ref_we = 1'b0;
    endtask

    task automatic run(input string name, input bit stray_start);
        int esad, edx, edy, ecyc;
        int n = 0;
        int hs, hx, hy;
        model(esad, edx, edy, ecyc);
        load();
        @(negedge clk); start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        while (!done && n < 4000) begin
            @(posedge clk); #1;
            n++;
            if (n == 1) check("R7", {name, " busy after start"}, int'(busy), 1);
            if (stray_start && n == 5) start = 1'b1;
            if (stray_start && n == 6) start = 1'b0;
        end
        check("R6", {name, " cycles to done"}, n, ecyc);
        check("R1", {name, " sad"}, int'(best_sad), esad);
        check("R2", {name, " mvx"}, int'(best_mvx), edx);
        check("R3", {name, " mvy"}, int'(best_mvy), edy);
        check("R7", {name, " idle at done"}, int'(busy), 0);
        hs = int'(best_sad); hx = int'(best_mvx); hy = int'(best_mvy);
        @(posedge clk); #1;
        check("R6", {name, " done one cycle"}, int'(done), 0);
        repeat (3) @(posedge clk);
        #1;
        check("R9", {name, " held"}, (int'(best_sad) == hs && int'(best_mvx) == hx &&
              int'(best_mvy) == hy) ? 1 : 0, 1);
    endtask

    task automatic plant(input int cx, input int cy);
        for (int i = 0; i < RW*RW; i++) refm[i] = rnd();
        for (int y = 0; y < B; y++)
            for (int x = 0; x < B; x++)
                curm[y*B+x] = refm[(y+cy)*RW + x + cx];
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R8", "busy in reset", int'(busy), 0);
        check("R8", "done in reset", int'(done), 0);
        check("R8", "sad in reset", int'(best_sad), 0);
        check("R8", "mv in reset", int'(best_mvx) + 8 * int'(best_mvy), 0);
        @(negedge clk); rst_n = 1'b1;

        // R3 / R2: exact copy planted at every candidate offset in turn
        for (int c = 0; c < S*S; c++) begin
            plant(c % S, c / S);
            run($sformatf("plant%0d", c), 1'b0);
        end

        // R5 / R4: zero-difference flat images: first candidate full, others drop after one row
        for (int i = 0; i < B*B; i++) curm[i] = 50;
        for (int i = 0; i < RW*RW; i++) refm[i] = 50;
        run("flat_zero", 1'b0);

        // R4 / R2: maximum contrast: every candidate ties at the largest sum, none drops
        for (int i = 0; i < B*B; i++) curm[i] = 255;
        for (int i = 0; i < RW*RW; i++) refm[i] = 0;
        run("max_tie", 1'b0);

        // R2: unrelated pseudo-random images
        for (int k = 0; k < 4; k++) begin
            for (int i = 0; i < B*B; i++) curm[i] = rnd();
            for (int i = 0; i < RW*RW; i++) refm[i] = rnd();
            run($sformatf("random%0d", k), 1'b0);
        end

        // R2: gradient reference with a noisy current block
        for (int y = 0; y < RW; y++)
            for (int x = 0; x < RW; x++)
                refm[y*RW+x] = x * 20 + y * 7;
        for (int y = 0; y < B; y++)
            for (int x = 0; x < B; x++)
                curm[y*B+x] = refm[(y+3)*RW + x + 1] + (x + y) % 3;
        run("gradient", 1'b0);

        // R7: stray start in mid-search must not disturb the result or timing
        plant(1, 2);
        run("stray_start", 1'b1);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule